// File: doc/BRIEF.md
# Latched Fault Blink-Code Indicator

This block reports a fatal fault on three status LEDs. A fault source outside the block raises a one-cycle strobe together with a numeric fault code. The block captures that code once and then enters an error mode that it never leaves on its own. In error mode it plays the same two-part pattern over and over. First, all three LEDs flash together for about two seconds to show that a fault happened. Then, after a dark pause, only the middle LED flashes, once for each unit of the captured code. A second dark pause follows, and the pattern starts again.

Someone watching the board counts the middle-LED flashes to read the code. The code also places the fault in one of three groups: usage faults, bus faults and memory-protection faults. The block reports that group as a two-bit class. All timing comes from a divider on the system clock. A tick lasts a quarter second, and every flash is one tick lit followed by one tick dark. The clock-frequency parameter can be lowered, so a simulation covers whole display loops in a few hundred cycles. Reset is asserted asynchronously and released in step with the clock.

Top module: `fault_blink_reporter`

## Requirements
- R1: While reset is held, and after it is released until a fault is captured, `led_en` is 000, `led_col` is 000, `err_active` is 0, `phase` is 0 (idle), `flash_cnt` is 0, `latched_code` is 0 and `fault_class` is 0.
- R2: A `fault_stb` pulse seen at a clock edge while idle is captured at that edge. From the next cycle, `err_active` is 1 and `phase` is 1 (announce).
- R3: The code is normalised when it is captured. A code of 0 is stored as 1, and a code above 16 is stored as 16. Codes 1 to 16 are stored unchanged in `latched_code`.
- R4: In error mode, a further `fault_stb` changes neither `latched_code` nor `fault_class` nor the blink sequence.
- R5: The announce phase (`phase` = 1) has four flashes. Each flash is T cycles with `led_en` = 111, then T cycles with `led_en` = 000, where T = CLK_HZ / TICKS_PER_SEC. While lit, `led_col` = 010: the outer LEDs (bits 0 and 2) use colour 0 and the middle LED (bit 1) uses colour 1.
- R6: After the announce phase comes a pause (`phase` = 2) of 6·T cycles with all LEDs dark.
- R7: The count phase (`phase` = 3) has exactly N flashes, where N is `latched_code`. Each flash is T cycles with `led_en` = 010, then T cycles with `led_en` = 000. The outer LEDs stay off, and `led_col` is 010 while the middle LED is lit.
- R8: `flash_cnt` rises by one at the start of each middle-LED flash in the count phase and holds N through the following pause.
- R9: After the count phase comes a second pause (`phase` = 4) of 6·T cycles with all LEDs dark. After that pause, the announce phase starts again, and the loop repeats for as long as error mode lasts.
- R10: `fault_class` is 1 for stored codes 1–6 (usage), 2 for codes 7–12 (bus) and 3 for codes 13–16 (memory protection).
- R11: Once `err_active` is 1, it stays 1 until reset is asserted. Reset returns the block to the state in R1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronised release |
| fault_stb | input | 1 | One-cycle fault indication |
| fault_code | input | 5 | Fault code that goes with the strobe |
| led_en | output | 3 | LED on enables: bit 0 left, bit 1 middle, bit 2 right |
| led_col | output | 3 | Colour select per LED, 0 = first colour, 1 = second colour |
| err_active | output | 1 | High while in the latched error mode |
| phase | output | 3 | 0 idle, 1 announce, 2 pause after announce, 3 count, 4 pause after count |
| flash_cnt | output | 5 | Middle-LED flashes started in the current count phase |
| latched_code | output | 5 | Stored, normalised fault code |
| fault_class | output | 2 | Fault group of the stored code |

## Verification
The scoreboard splits the output into runs of constant phase and LED pattern, and it checks both the pattern and the exact length of each run. A design that is off by one tick, or that lets an LED flash one time too many or too few, shows up as a run of the wrong length or a missing segment. The edge codes get their own runs. Code 1 gives a count phase of a single flash, code 16 gives the longest count phase, and codes 0 and 23 must be folded into that range. A design that does not fold them would stall in the count phase or flash the wrong number of times. A second strobe is fired in the middle of a run: a design that lets it through would change the stored code or break the expected sequence. The bench also probes the class boundaries at 6/7 and 12/13, and it checks that error mode survives long runs and is cleared only by reset.

// File: rtl/blink_pkg.sv
package blink_pkg;

  typedef enum logic [2:0] {
    PH_IDLE     = 3'd0,
    PH_ANNOUNCE = 3'd1,
    PH_PAUSE_A  = 3'd2,
    PH_COUNT    = 3'd3,
    PH_PAUSE_B  = 3'd4
  } phase_e;

  typedef enum logic [1:0] {
    CLS_NONE   = 2'd0,
    CLS_USAGE  = 2'd1,
    CLS_BUS    = 2'd2,
    CLS_MEMORY = 2'd3
  } fault_class_e;

  // LED lane positions inside the 3-bit enable / colour vectors
  localparam int unsigned LANE_LEFT  = 0;
  localparam int unsigned LANE_MID   = 1;
  localparam int unsigned LANE_RIGHT = 2;
  localparam int unsigned LANES      = 3;

endpackage

// File: rtl/blink_reset_sync.sv
module blink_reset_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_core_n = sync_q[STAGES-1];

endmodule

// File: rtl/blink_tick_gen.sv
module blink_tick_gen #(
  parameter  int unsigned TICK_CYC = 8,
  localparam int unsigned CNT_W    = (TICK_CYC > 1) ? $clog2(TICK_CYC) : 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             wrap;

  assign wrap = (cnt_q == CNT_W'(TICK_CYC - 1));

  always_comb begin
    cnt_en = 1'b1;
    if (!run) begin
      cnt_d  = '0;
      cnt_en = (cnt_q != '0);
    end else if (wrap) begin
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign tick = run && wrap;

endmodule

// File: rtl/fault_code_latch.sv
module fault_code_latch
  import blink_pkg::*;
#(
  parameter int unsigned CODE_W     = 5,
  parameter int unsigned MAX_CODE   = 16,
  parameter int unsigned USAGE_LAST = 6,
  parameter int unsigned BUS_LAST   = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [CODE_W-1:0] code_in,
  output logic              start,
  output logic              active,
  output logic [CODE_W-1:0] code_q,
  output logic [1:0]        class_q
);

  logic              active_q;
  logic [CODE_W-1:0] norm_code;
  fault_class_e      norm_class;
  logic [CODE_W-1:0] code_d;
  logic [1:0]        class_d;

  // capture only the first strobe; later ones fall on a set latch
  assign start = stb && !active_q;

  always_comb begin
    if (code_in == '0) begin
      norm_code = CODE_W'(1);
    end else if (code_in > CODE_W'(MAX_CODE)) begin
      norm_code = CODE_W'(MAX_CODE);
    end else begin
      norm_code = code_in;
    end

    if (norm_code <= CODE_W'(USAGE_LAST)) begin
      norm_class = CLS_USAGE;
    end else if (norm_code <= CODE_W'(BUS_LAST)) begin
      norm_class = CLS_BUS;
    end else begin
      norm_class = CLS_MEMORY;
    end

    code_d  = norm_code;
    class_d = norm_class;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      code_q   <= '0;
      class_q  <= CLS_NONE;
    end else if (start) begin
      active_q <= 1'b1;
      code_q   <= code_d;
      class_q  <= class_d;
    end
  end

  assign active = active_q;

endmodule

// File: rtl/blink_sequencer.sv
module blink_sequencer
  import blink_pkg::*;
#(
  parameter  int unsigned CODE_W           = 5,
  parameter  int unsigned MAX_CODE         = 16,
  parameter  int unsigned ANNOUNCE_FLASHES = 4,
  parameter  int unsigned GAP_TICKS        = 6,
  localparam int unsigned ANN_STEPS        = 2 * ANNOUNCE_FLASHES,
  localparam int unsigned CNT_STEPS_MAX    = 2 * MAX_CODE,
  localparam int unsigned STEP_MAX_A       = (ANN_STEPS > GAP_TICKS) ? ANN_STEPS : GAP_TICKS,
  localparam int unsigned STEP_MAX         = (STEP_MAX_A > CNT_STEPS_MAX) ? STEP_MAX_A : CNT_STEPS_MAX,
  localparam int unsigned STEP_W           = $clog2(STEP_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              active,
  input  logic              tick,
  input  logic [CODE_W-1:0] code,
  output logic [2:0]        phase_o,
  output logic [LANES-1:0]  led_en,
  output logic [LANES-1:0]  led_col,
  output logic [CODE_W-1:0] flash_cnt
);

  phase_e            ph_q, ph_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [CODE_W-1:0] fcnt_q, fcnt_d;
  logic              seq_en;
  logic              lit;
  logic [STEP_W-1:0] count_last;
  logic              ann_done, gap_done, cnt_done;

  assign count_last = STEP_W'((32'(code) << 1) - 32'd1);
  assign ann_done   = (step_q == STEP_W'(ANN_STEPS - 1));
  assign gap_done   = (step_q == STEP_W'(GAP_TICKS - 1));
  assign cnt_done   = (step_q == count_last);
  // even steps are the lit half of a flash
  assign lit        = !step_q[0];

  // next-state process
  always_comb begin
    ph_d   = ph_q;
    step_d = step_q;
    fcnt_d = fcnt_q;
    seq_en = 1'b0;
    if (start) begin
      seq_en = 1'b1;
      ph_d   = PH_ANNOUNCE;
      step_d = '0;
    end else if (active && tick) begin
      seq_en = 1'b1;
      step_d = step_q + STEP_W'(1);
      unique case (ph_q)
        PH_ANNOUNCE: begin
          if (ann_done) begin
            ph_d   = PH_PAUSE_A;
            step_d = '0;
          end
        end
        PH_PAUSE_A: begin
          if (gap_done) begin
            ph_d   = PH_COUNT;
            step_d = '0;
            fcnt_d = CODE_W'(1);
          end
        end
        PH_COUNT: begin
          if (cnt_done) begin
            ph_d   = PH_PAUSE_B;
            step_d = '0;
          end else if (step_q[0]) begin
            fcnt_d = fcnt_q + CODE_W'(1);
          end
        end
        PH_PAUSE_B: begin
          if (gap_done) begin
            ph_d   = PH_ANNOUNCE;
            step_d = '0;
          end
        end
        default: begin
          ph_d   = PH_IDLE;
          step_d = '0;
        end
      endcase
    end
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_IDLE;
      step_q <= '0;
      fcnt_q <= '0;
    end else if (seq_en) begin
      ph_q   <= ph_d;
      step_q <= step_d;
      fcnt_q <= fcnt_d;
    end
  end

  // output decode, one lane at a time
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam bit IS_MID = (g == LANE_MID);
    always_comb begin
      led_en[g]  = 1'b0;
      led_col[g] = 1'b0;
      if (ph_q == PH_ANNOUNCE) begin
        led_en[g] = lit;
      end else if (ph_q == PH_COUNT) begin
        led_en[g] = lit && IS_MID;
      end
      if (ph_q != PH_IDLE) begin
        led_col[g] = IS_MID;
      end
    end
  end

  assign phase_o   = ph_q;
  assign flash_cnt = fcnt_q;

endmodule

// File: rtl/fault_blink_reporter.sv
module fault_blink_reporter
  import blink_pkg::*;
#(
  parameter  int unsigned CLK_HZ           = 125_000_000,
  parameter  int unsigned TICKS_PER_SEC    = 4,
  parameter  int unsigned ANNOUNCE_FLASHES = 4,
  parameter  int unsigned GAP_TICKS        = 6,
  parameter  int unsigned MAX_CODE         = 16,
  parameter  int unsigned USAGE_LAST       = 6,
  parameter  int unsigned BUS_LAST         = 12,
  parameter  int unsigned CODE_W           = 5,
  localparam int unsigned TICK_CYC         = CLK_HZ / TICKS_PER_SEC
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_stb,
  input  logic [CODE_W-1:0] fault_code,
  output logic [2:0]        led_en,
  output logic [2:0]        led_col,
  output logic              err_active,
  output logic [2:0]        phase,
  output logic [CODE_W-1:0] flash_cnt,
  output logic [CODE_W-1:0] latched_code,
  output logic [1:0]        fault_class
);

  logic rst_core_n;
  logic start;
  logic active;
  logic tick;

  blink_reset_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  fault_code_latch #(
    .CODE_W     (CODE_W),
    .MAX_CODE   (MAX_CODE),
    .USAGE_LAST (USAGE_LAST),
    .BUS_LAST   (BUS_LAST)
  ) u_latch (
    .clk     (clk),
    .rst_n   (rst_core_n),
    .stb     (fault_stb),
    .code_in (fault_code),
    .start   (start),
    .active  (active),
    .code_q  (latched_code),
    .class_q (fault_class)
  );

  blink_tick_gen #(.TICK_CYC(TICK_CYC)) u_tick (
    .clk   (clk),
    .rst_n (rst_core_n),
    .run   (active),
    .tick  (tick)
  );

  blink_sequencer #(
    .CODE_W           (CODE_W),
    .MAX_CODE         (MAX_CODE),
    .ANNOUNCE_FLASHES (ANNOUNCE_FLASHES),
    .GAP_TICKS        (GAP_TICKS)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .start     (start),
    .active    (active),
    .tick      (tick),
    .code      (latched_code),
    .phase_o   (phase),
    .led_en    (led_en),
    .led_col   (led_col),
    .flash_cnt (flash_cnt)
  );

  assign err_active = active;

endmodule

// File: rtl/fault_blink_checker.sv
module fault_blink_checker
  import blink_pkg::*;
#(
  parameter int unsigned CODE_W   = 5,
  parameter int unsigned MAX_CODE = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fault_stb,
  input logic [2:0]        led_en,
  input logic [2:0]        led_col,
  input logic              err_active,
  input logic [2:0]        phase,
  input logic [CODE_W-1:0] flash_cnt,
  input logic [CODE_W-1:0] latched_code,
  input logic [1:0]        fault_class
);

  a_r1_idle_dark: assert property (@(posedge clk) disable iff (!rst_n)
    !err_active |-> (led_en == 3'b000 && phase == PH_IDLE));

  a_r3_code_range: assert property (@(posedge clk) disable iff (!rst_n)
    err_active |-> (latched_code >= CODE_W'(1) && latched_code <= CODE_W'(MAX_CODE)));

  a_r4_code_held: assert property (@(posedge clk) disable iff (!rst_n)
    (err_active && fault_stb) |=> ($stable(latched_code) && $stable(fault_class)));

  a_r5_announce_together: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_ANNOUNCE) |-> (led_en == 3'b000 || led_en == 3'b111));

  a_r6_r9_pause_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_PAUSE_A || phase == PH_PAUSE_B) |-> (led_en == 3'b000));

  a_r7_outer_off: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COUNT) |-> (!led_en[LANE_LEFT] && !led_en[LANE_RIGHT]));

  a_r7_mid_colour: assert property (@(posedge clk) disable iff (!rst_n)
    led_en[LANE_MID] |-> led_col[LANE_MID]);

  a_r8_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_COUNT) |-> (flash_cnt >= CODE_W'(1) && flash_cnt <= latched_code));

  a_r10_class_set: assert property (@(posedge clk) disable iff (!rst_n)
    err_active |-> (fault_class != CLS_NONE));

  a_r11_stays_active: assert property (@(posedge clk) disable iff (!rst_n)
    err_active |=> err_active);

endmodule

bind fault_blink_reporter fault_blink_checker #(
  .CODE_W   (CODE_W),
  .MAX_CODE (MAX_CODE)
) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fault_stb    (fault_stb),
  .led_en       (led_en),
  .led_col      (led_col),
  .err_active   (err_active),
  .phase        (phase),
  .flash_cnt    (flash_cnt),
  .latched_code (latched_code),
  .fault_class  (fault_class)
);

// File: tb/fault_blink_reporter_tb.sv
`timescale 1ns/1ps
module fault_blink_reporter_tb;

  localparam int CLK_HZ = 32;
  localparam int TPS    = 4;
  localparam int T      = CLK_HZ / TPS;
  localparam int AF     = 4;
  localparam int GAP    = 6;

  logic       clk;
  logic       rst_n;
  logic       fault_stb;
  logic [4:0] fault_code;
  logic [2:0] led_en;
  logic [2:0] led_col;
  logic       err_active;
  logic [2:0] phase;
  logic [4:0] flash_cnt;
  logic [4:0] latched_code;
  logic [1:0] fault_class;

  fault_blink_reporter #(.CLK_HZ(CLK_HZ), .TICKS_PER_SEC(TPS)) u_dut (
    .clk          (clk),
    .rst_n        (rst_n),
    .fault_stb    (fault_stb),
    .fault_code   (fault_code),
    .led_en       (led_en),
    .led_col      (led_col),
    .err_active   (err_active),
    .phase        (phase),
    .flash_cnt    (flash_cnt),
    .latched_code (latched_code),
    .fault_class  (fault_class)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  typedef struct {
    logic [2:0] ph;
    logic [2:0] leds;
    int         len;
  } seg_t;

  seg_t exp_q[$];

  bit         mon_on    = 1'b0;
  bit         seg_valid = 1'b0;
  logic [2:0] seg_ph;
  logic [2:0] seg_leds;
  int         seg_len;
  int         cur_n;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic string req_of(input logic [2:0] ph);
    case (ph)
      3'd1:    return "R5 announce";
      3'd2:    return "R6 pause after announce";
      3'd3:    return "R7 count";
      3'd4:    return "R9 pause after count";
      default: return "R2 phase";
    endcase
  endfunction

  // driver side: expected runs of constant phase and LED pattern
  task automatic push_loops(input int n, input int loops);
    for (int l = 0; l < loops; l++) begin
      for (int f = 0; f < AF; f++) begin
        exp_q.push_back('{3'd1, 3'b111, T});
        exp_q.push_back('{3'd1, 3'b000, T});
      end
      exp_q.push_back('{3'd2, 3'b000, GAP * T});
      for (int f = 0; f < n; f++) begin
        exp_q.push_back('{3'd3, 3'b010, T});
        exp_q.push_back('{3'd3, 3'b000, T});
      end
      exp_q.push_back('{3'd4, 3'b000, GAP * T});
    end
  endtask

  function automatic int loop_cycles(input int n);
    return T * (2 * AF + 2 * GAP + 2 * n);
  endfunction

  // monitor: close each run and compare with the scoreboard head
  always @(negedge clk) begin
    if (mon_on && err_active) begin
      if (!seg_valid) begin
        seg_valid = 1'b1;
        seg_ph    = phase;
        seg_leds  = led_en;
        seg_len   = 1;
      end else if (phase == seg_ph && led_en == seg_leds) begin
        seg_len++;
      end else begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R9 scoreboard underrun", 1, 0);
        end else begin
          seg_t e;
          e = exp_q.pop_front();
          check({seg_ph, seg_leds} == {e.ph, e.leds}, req_of(e.ph),
                int'({seg_ph, seg_leds}), int'({e.ph, e.leds}));
          check(seg_len == e.len, req_of(e.ph), seg_len, e.len);
        end
        if (phase == 3'd4) begin
          check(flash_cnt == 5'(cur_n), "R8 flash count", int'(flash_cnt), cur_n);
        end
        if (led_en != 3'b000) begin
          check(led_col == 3'b010, "R5/R7 colour", int'(led_col), 2);
        end
        seg_ph   = phase;
        seg_leds = led_en;
        seg_len  = 1;
      end
    end
  end

  task automatic summary;
    $display("  %0d/%0d checks passed", checks - fails, checks);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      check(1'b0, "R11 watchdog", cycles, 150000);
      summary();
      $finish;
    end
  end

  task automatic check_idle(input string tag);
    check(led_en == 3'b000 && led_col == 3'b000, {tag, " leds"}, int'({led_en, led_col}), 0);
    check(!err_active && phase == 3'd0, {tag, " mode"}, int'({err_active, phase}), 0);
    check(flash_cnt == 0 && latched_code == 0 && fault_class == 0, {tag, " state"},
          int'({flash_cnt, latched_code, fault_class}), 0);
  endtask

  task automatic do_reset;
    @(negedge clk);
    mon_on    = 1'b0;
    rst_n     = 1'b0;
    fault_stb = 1'b0;
    repeat (3) @(negedge clk);
    check_idle("R1 during reset");
    #1 rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_idle("R1 after reset");
    exp_q.delete();
    seg_valid = 1'b0;
  endtask

  task automatic fire(input logic [4:0] c);
    @(negedge clk);
    #1;
    fault_stb  = 1'b1;
    fault_code = c;
    @(negedge clk);
    #1;
    fault_stb  = 1'b0;
    fault_code = 5'd0;
  endtask

  task automatic run_code(input logic [4:0] c, input int n, input int cls);
    cur_n  = n;
    push_loops(n, 3);
    mon_on = 1'b1;
    fire(c);
    check(err_active == 1'b1 && phase == 3'd1, "R2 capture", int'({err_active, phase}), 9);
    check(latched_code == 5'(n), "R3 stored code", int'(latched_code), n);
    check(fault_class == 2'(cls), "R10 class", int'(fault_class), cls);
    repeat (2 * loop_cycles(n) + T) @(negedge clk);
    check(err_active == 1'b1, "R11 still latched", int'(err_active), 1);
  endtask

  task automatic class_probe(input logic [4:0] c, input int n, input int cls);
    do_reset();
    fire(c);
    check(latched_code == 5'(n), "R3 stored code", int'(latched_code), n);
    check(fault_class == 2'(cls), "R10 class boundary", int'(fault_class), cls);
  endtask

  initial begin
    rst_n      = 1'b0;
    fault_stb  = 1'b0;
    fault_code = 5'd0;
    cur_n      = 0;

    do_reset();
    // R1: idle for a while without a strobe
    repeat (3 * T) @(negedge clk);
    check_idle("R1 idle wait");

    // main loop with a second strobe fired mid-run (R4)
    cur_n  = 5;
    push_loops(5, 3);
    mon_on = 1'b1;
    fire(5'd5);
    check(err_active == 1'b1 && phase == 3'd1, "R2 capture", int'({err_active, phase}), 9);
    check(fault_class == 2'd1, "R10 class", int'(fault_class), 1);
    repeat (loop_cycles(5) + 3 * T) @(negedge clk);
    fire(5'd9);
    check(latched_code == 5'd5, "R4 code kept", int'(latched_code), 5);
    check(fault_class == 2'd1, "R4 class kept", int'(fault_class), 1);
    repeat (loop_cycles(5)) @(negedge clk);
    check(err_active == 1'b1, "R11 still latched", int'(err_active), 1);

    // R11: reset clears error mode
    do_reset();

    run_code(5'd0, 1, 1);     // R3 zero folds to one
    do_reset();
    run_code(5'd16, 16, 3);   // R7 longest count
    do_reset();
    run_code(5'd9, 9, 2);     // R10 bus group

    class_probe(5'd23, 16, 3); // R3 saturation
    class_probe(5'd6, 6, 1);   // R10 boundaries
    class_probe(5'd7, 7, 2);
    class_probe(5'd12, 12, 2);
    class_probe(5'd13, 13, 3);

    do_reset();
    summary();
    $finish;
  end

endmodule